// File: doc/BRIEF.md
# Signalling Tone Burst Sequencer

This block decides when a dual-tone signalling transmitter is allowed to sound. It takes the control bits and the four-bit transmit digit from a register bank written over a processor bus. It also takes a one-millisecond tick from a shared timebase. From these it drives a tone gate, the two group-select lines that choose dual-tone, row-only or column-only output, a one-cycle ready pulse for the status logic, an interrupt request and an oscillator power-down line. The tone synthesiser, the converter and the filters sit downstream and are not part of it.

The block has two modes. In burst mode, each digit write produces a timed tone followed by a silent pause of the same length. Both last `BURST_MS` ticks, and both stretch by `CP_FACTOR` while call-progress mode is set. A digit that arrives while a burst or pause is running waits in a single holding slot. It starts as soon as the current pause finishes. In continuous mode, the tone simply follows an enable bit.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, tone_gate, row_en, col_en, tx_ready and irq_req are 0 and digit_out is 0.
- R2: burst_n is active low. With burst_n = 0 and no burst or pause in progress, a digit_wr pulse makes tone_gate 1 from the next clock onward.
- R3: In burst mode the tone stays on for exactly BURST_MS sampled ticks. It is then followed by a pause, with tone_gate at 0, of exactly BURST_MS sampled ticks.
- R4: If cp_mode is 1 in the cycle a burst starts, both tone and pause last BURST_MS*CP_FACTOR ticks. Changing cp_mode later does not alter that burst.
- R5: tx_ready is high for exactly one clock, in the cycle after the clock edge that samples the final pause tick. irq_req equals tx_ready while irq_en is 1 and stays 0 otherwise.
- R6: A digit written during a tone or pause is held and starts the next tone in the same cycle that tx_ready rises. A second write before then replaces the held digit.
- R7: A digit written in the very cycle the pause ends starts the next tone at once, and tx_ready still pulses in that cycle.
- R8: With burst_n = 1, tone_gate equals tone_en and tx_ready stays 0. Raising burst_n mid-burst ends the burst and discards any held digit, so returning to burst mode leaves the tone off.
- R9: With single_sel = 0 both row_en and col_en follow tone_gate. With single_sel = 1 only col_en follows it when col_sel = 1, and only row_en when col_sel = 0.
- R10: osc_pd is 1 exactly when rx_en_n = 1, tone_en = 0 and no burst or pause is in progress.
- R11: digit_out shows the digit of the burst in progress in burst mode, and the last digit written in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| burst_n | input | 1 | 0 = burst mode, 1 = continuous mode |
| cp_mode | input | 1 | Call-progress mode, multiplies burst and pause length |
| tone_en | input | 1 | Tone enable in continuous mode, transmitter power |
| single_sel | input | 1 | 0 = dual tone, 1 = single tone |
| col_sel | input | 1 | Single-tone group: 1 = column, 0 = row |
| rx_en_n | input | 1 | Receiver enable, active low |
| irq_en | input | 1 | Interrupt enable |
| digit_wr | input | 1 | Transmit digit write strobe |
| digit_in | input | 4 | Digit code being written |
| tone_gate | output | 1 | Tone on |
| row_en | output | 1 | Row (low group) tone enable |
| col_en | output | 1 | Column (high group) tone enable |
| digit_out | output | 4 | Digit being sent |
| tx_ready | output | 1 | One-cycle pulse when a pause completes |
| irq_req | output | 1 | Interrupt request pulse |
| osc_pd | output | 1 | Oscillator power-down |

## Verification
Two functions can fall in the same cycle: the end of a pause and a new digit write, which either occupy the holding slot or start a tone directly. The bench times one write to land on the exact edge that samples the last pause tick, using its own model's tick count. It expects tx_ready high, tone_gate high and digit_out equal to the new digit at the same sample. It also overwrites a held digit during a tone and checks that only the later digit is sent once the pause has finished.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TONE  = 2'd1,
        ST_PAUSE = 2'd2
    } state_e;

    typedef struct packed {
        state_e               st;
        logic                 cp;
        logic [DIGIT_W-1:0]   cur;
        logic                 pend_v;
        logic [DIGIT_W-1:0]   pend;
        logic                 ready;
    } seq_t;

endpackage

// File: rtl/tbs_timer.sv
module tbs_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = tick && !clear && (cnt_q == limit - 1'b1);
        cnt_d = cnt_q;
        if (clear || done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tbs_group.sv
module tbs_group (
    input  logic gate,
    input  logic single_sel,
    input  logic col_sel,
    output logic row_en,
    output logic col_en
);
    always_comb begin
        row_en = gate && (!single_sel || !col_sel);
        col_en = gate && (!single_sel ||  col_sel);
    end
endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq #(
    parameter int BURST_MS  = 51,
    parameter int CP_FACTOR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       burst_n,
    input  logic       cp_mode,
    input  logic       tone_en,
    input  logic       single_sel,
    input  logic       col_sel,
    input  logic       rx_en_n,
    input  logic       irq_en,
    input  logic       digit_wr,
    input  logic [3:0] digit_in,
    output logic       tone_gate,
    output logic       row_en,
    output logic       col_en,
    output logic [3:0] digit_out,
    output logic       tx_ready,
    output logic       irq_req,
    output logic       osc_pd
);
    import tbs_pkg::*;

    localparam int LONG_MS = BURST_MS * CP_FACTOR;
    localparam int CNT_W   = $clog2(LONG_MS + 1);

    seq_t             r_d, r_q;
    logic [CNT_W-1:0] limit;
    logic             tmr_clear;
    logic             tmr_done;
    state_e           st_q;

    assign st_q      = r_q.st;
    assign limit     = r_q.cp ? CNT_W'(LONG_MS) : CNT_W'(BURST_MS);
    assign tmr_clear = burst_n || (r_q.st == ST_IDLE);

    tbs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (ms_tick),
        .limit (limit),
        .done  (tmr_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        if (burst_n) begin
            r_d.st     = ST_IDLE;
            r_d.pend_v = 1'b0;
            if (digit_wr) begin
                r_d.cur = digit_in;
            end
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (digit_wr) begin
                        r_d.st  = ST_TONE;
                        r_d.cur = digit_in;
                        r_d.cp  = cp_mode;
                    end
                end
                ST_TONE: begin
                    if (digit_wr) begin
                        r_d.pend_v = 1'b1;
                        r_d.pend   = digit_in;
                    end
                    if (tmr_done) begin
                        r_d.st = ST_PAUSE;
                    end
                end
                ST_PAUSE: begin
                    if (tmr_done) begin
                        r_d.ready  = 1'b1;
                        r_d.pend_v = 1'b0;
                        if (digit_wr) begin
                            r_d.st  = ST_TONE;
                            r_d.cur = digit_in;
                            r_d.cp  = cp_mode;
                        end else if (r_q.pend_v) begin
                            r_d.st  = ST_TONE;
                            r_d.cur = r_q.pend;
                            r_d.cp  = cp_mode;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else if (digit_wr) begin
                        r_d.pend_v = 1'b1;
                        r_d.pend   = digit_in;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tone_gate = burst_n ? tone_en : (r_q.st == ST_TONE);
    assign digit_out = r_q.cur;
    assign tx_ready  = r_q.ready;
    assign irq_req   = r_q.ready && irq_en;
    assign osc_pd    = rx_en_n && !tone_en && (r_q.st == ST_IDLE);

    tbs_group u_group (
        .gate       (tone_gate),
        .single_sel (single_sel),
        .col_sel    (col_sel),
        .row_en     (row_en),
        .col_en     (col_en)
    );
endmodule

// File: rtl/tbs_checks.sv
module tbs_checks (
    input logic            clk,
    input logic            rst_n,
    input logic            burst_n,
    input logic            digit_wr,
    input logic            single_sel,
    input logic            tone_gate,
    input logic            row_en,
    input logic            col_en,
    input logic            tx_ready,
    input logic            osc_pd,
    input tbs_pkg::state_e st
);
    import tbs_pkg::*;

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_n && digit_wr && st == ST_IDLE) |=> (tone_gate || burst_n));

    p_pause_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_n && st == ST_PAUSE) |-> !tone_gate);

    p_rdy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    p_rdy_from_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> $past(st == ST_PAUSE));

    p_no_ready_cont_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(burst_n) |-> !tx_ready);

    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        single_sel |-> !(row_en && col_en));

    p_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        osc_pd |-> !tone_gate);
endmodule

bind tone_burst_seq tbs_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_n    (burst_n),
    .digit_wr   (digit_wr),
    .single_sel (single_sel),
    .tone_gate  (tone_gate),
    .row_en     (row_en),
    .col_en     (col_en),
    .tx_ready   (tx_ready),
    .osc_pd     (osc_pd),
    .st         (st_q)
);

// File: tb/sim_tone_burst_seq.sv
`timescale 1ns/1ps
module sim_tone_burst_seq;
    localparam int N  = 51;
    localparam int CF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, burst_n = 1'b1, cp_mode = 1'b0, tone_en = 1'b0;
    logic single_sel = 1'b0, col_sel = 1'b0, rx_en_n = 1'b0, irq_en = 1'b0;
    logic digit_wr = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic tone_gate, row_en, col_en, tx_ready, irq_req, osc_pd;
    logic [3:0] digit_out;

    always #2 clk = ~clk;

    tone_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .burst_n(burst_n),
        .cp_mode(cp_mode), .tone_en(tone_en), .single_sel(single_sel),
        .col_sel(col_sel), .rx_en_n(rx_en_n), .irq_en(irq_en),
        .digit_wr(digit_wr), .digit_in(digit_in), .tone_gate(tone_gate),
        .row_en(row_en), .col_en(col_en), .digit_out(digit_out),
        .tx_ready(tx_ready), .irq_req(irq_req), .osc_pd(osc_pd)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done_flag = 0;
    string gate_tag = "R1";
    bit    tick_ph = 0;
    int    ton = 0, pse = 0;

    // behavioural reference: 0 idle, 1 tone, 2 pause
    int    m_st = 0, m_cnt = 0, m_len = N, m_cur = 0;
    bit    m_rdy = 0;
    int    pq[$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_start(input int d);
        m_st = 1; m_cur = d; m_cnt = 0; m_len = cp_mode ? N*CF : N;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cur = 0; m_rdy = 0; pq.delete();
        end else begin
            m_rdy = 0;
            if (burst_n) begin
                m_st = 0; m_cnt = 0; pq.delete();
                if (digit_wr) m_cur = digit_in;
            end else if (m_st == 0) begin
                if (digit_wr) m_start(digit_in);
            end else begin
                if (ms_tick) m_cnt++;
                if (m_cnt == m_len) begin
                    m_cnt = 0;
                    if (m_st == 1) begin
                        m_st = 2;
                        if (digit_wr) begin pq.delete(); pq.push_back(digit_in); end
                    end else begin
                        m_rdy = 1;
                        if (digit_wr) begin pq.delete(); m_start(digit_in); end
                        else if (pq.size() > 0) m_start(pq.pop_front());
                        else m_st = 0;
                    end
                end else if (digit_wr) begin
                    pq.delete(); pq.push_back(digit_in);
                end
            end
            if (ms_tick && !burst_n) begin
                if (tone_gate) ton++; else pse++;
            end
            #1;
            if (!done_flag) begin
                int eg;
                eg = burst_n ? tone_en : (m_st == 1);
                chk(gate_tag, tone_gate, eg);
                chk("R9 row", row_en, eg && (!single_sel || !col_sel));
                chk("R9 col", col_en, eg && (!single_sel || col_sel));
                chk("R5 ready", tx_ready, m_rdy);
                chk("R5 irq", irq_req, m_rdy && irq_en);
                chk("R10", osc_pd, rx_en_n && !tone_en && m_st == 0);
                chk("R11", digit_out, m_cur);
            end
        end
    end

    task automatic step(input bit wr, input int d);
        @(negedge clk);
        ms_tick = tick_ph; tick_ph = ~tick_ph;
        digit_wr = wr; digit_in = 4'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000; i++) begin
            step(0, 0);
            if (tx_ready) return;
        end
        chk("R5 ready timeout", 0, 1);
    endtask

    task automatic burst_len(input int d, input int exp_ticks, input string req);
        step(1, d);
        step(0, 0);
        ton = 0; pse = 0;
        if (req == "R4") cp_mode = ~cp_mode;
        wait_ready();
        chk({req, " tone ticks"}, ton, exp_ticks);
        chk({req, " pause ticks"}, pse, exp_ticks);
        step(0, 0);
        chk("R5 single cycle", tx_ready, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 gate", tone_gate, 0);
        chk("R1 ready", tx_ready, 0);
        chk("R1 digit", digit_out, 0);
        chk("R1 groups", row_en | col_en, 0);
        rst_n = 1'b1;

        // continuous mode
        gate_tag = "R8";
        idle(3);
        tone_en = 1; step(1, 7); idle(2);
        single_sel = 1; col_sel = 0; idle(2);
        col_sel = 1; idle(2);
        single_sel = 0; tone_en = 0; rx_en_n = 1; idle(2);
        step(1, 12); rx_en_n = 0; idle(2);

        // burst mode basic
        burst_n = 0; irq_en = 1; gate_tag = "R3";
        idle(3);
        chk("R2 idle gate", tone_gate, 0);
        step(1, 5);
        step(0, 0);
        chk("R2 start", tone_gate, 1);
        wait_ready();
        idle(4);
        burst_len(3, N, "R3");
        single_sel = 1; col_sel = 1; irq_en = 0;
        idle(3);

        // call-progress length, cp toggled mid-burst
        gate_tag = "R4";
        cp_mode = 1;
        burst_len(8, N*CF, "R4");
        cp_mode = 0; single_sel = 0; irq_en = 1;
        idle(3);

        // held digit replaced
        gate_tag = "R6";
        step(1, 10); idle(10);
        step(1, 11); idle(10);
        step(1, 13);
        wait_ready();
        chk("R6 chained gate", tone_gate, 1);
        chk("R6 held digit", digit_out, 13);
        wait_ready();
        idle(3);

        // write on the pause-ending edge
        gate_tag = "R7";
        step(1, 2);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            ms_tick = tick_ph; tick_ph = ~tick_ph;
            digit_wr = (m_st == 2 && m_cnt == m_len - 1 && ms_tick);
            digit_in = 4'd9;
            if (digit_wr) break;
        end
        step(0, 0);
        chk("R7 ready", tx_ready, 1);
        chk("R7 gate", tone_gate, 1);
        chk("R7 digit", digit_out, 9);

        // abort by leaving burst mode
        gate_tag = "R8";
        idle(10);
        step(1, 4);
        burst_n = 1; tone_en = 0; idle(5);
        chk("R8 abort gate", tone_gate, 0);
        burst_n = 0; idle(300);
        chk("R8 no held burst", tone_gate, 0);
        idle(2);
        finish_run();
    end
endmodule